// File: doc/BRIEF.md
# Dual-Mode Hash Message Schedule Generator

This block turns one 512-bit message block into the stream of 32-bit round words used by a SHA-1 or a SHA-256 compression engine. The block is delivered as sixteen 32-bit words on a word-serial load port. The first word loaded is the most significant word of the block. A mode input chosen at the start of the load selects the algorithm for the whole block.

After loading, the compression engine pulls words one at a time with an advance strobe. Each accepted advance returns the next round word with a valid flag. The final word of the block also carries a last flag. Round words 0 to 15 are the loaded words in order. From round 16 onward each word is computed from earlier words using the expansion rule of the selected algorithm.

Both algorithms share a single sixteen-word sliding window and one expansion stage. The window moves by one word on every accepted advance, so storage stays at sixteen words even when eighty rounds are produced.

Top module: `msg_sched_dual`

## Requirements
- R1: After reset `word_valid_o`, `last_o` and `word_o` are all 0, and an advance that arrives before any load produces no valid word.
- R2: Rounds 0 to 15 return the sixteen loaded words in the order they were loaded.
- R3: With `mode_i` = 0 (SHA-1), round t ≥ 16 is W[t] = ROTL1(W[t-3] ^ W[t-8] ^ W[t-14] ^ W[t-16]).
- R4: With `mode_i` = 1 (SHA-256), round t ≥ 16 is W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32. Here s0 = ROTR7 ^ ROTR18 ^ SHR3 and s1 = ROTR17 ^ ROTR19 ^ SHR10.
- R5: In SHA-1 mode exactly 80 words are produced, and `last_o` is high only together with word 79.
- R6: In SHA-256 mode exactly 64 words are produced, and `last_o` is high only together with word 63.
- R7: `word_valid_o` is high for exactly one cycle, in the cycle after each advance accepted during the run phase. It is low in every other cycle, including idle gaps between advances.
- R8: Advances after the last word produce no valid output until a new load has begun.
- R9: `mode_i` is sampled only with the first load word of a block. Changes to it during the remaining fifteen load words have no effect.
- R10: An advance asserted while a block is still being loaded is ignored. The first advance after the load completes returns word 0.
- R11: `load_valid_i` asserted while round words are still being produced is ignored. The ongoing sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Algorithm select: 0 = SHA-1, 1 = SHA-256; sampled with the first load word |
| load_valid_i | input | 1 | A message word is present on `load_word_i` this cycle |
| load_word_i | input | 32 | Message word, most significant word of the block first |
| adv_i | input | 1 | Request the next round word |
| word_o | output | 32 | Current round word |
| word_valid_o | output | 1 | `word_o` holds a new round word this cycle |
| last_o | output | 1 | `word_o` is the final round word of the block |

## Verification
Load words are accepted at the clock edge where they are presented. The run phase begins at the edge that takes the sixteenth word, so an advance may be driven in the very next cycle. Each round word, its valid flag and its last flag come from registers that update on the edge that sees the advance. The bench therefore drives inputs on the falling edge, lets one rising edge pass, and samples at the next falling edge. Cycles with no advance, or with an advance that must be ignored, are sampled the same way. At those points the bench expects `word_valid_o` to be low.

// File: rtl/msg_sched_pkg.sv
`timescale 1ns/1ps
package msg_sched_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } sched_state_e;

    typedef enum logic {
        ALG_SHA1   = 1'b0,
        ALG_SHA256 = 1'b1
    } alg_e;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t rotl1(input word_t x);
        return {x[WORD_W-2:0], x[WORD_W-1]};
    endfunction

    function automatic word_t lsig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t lsig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction
endpackage

// File: rtl/sched_expand.sv
`timescale 1ns/1ps
module sched_expand
    import msg_sched_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0][WORD_W-1:0] win_i,
    input  alg_e                         alg_i,
    output word_t                        next_o
);
    // window slot k holds W[t+k]; the word produced is W[t+DEPTH]
    localparam int S1_A = DEPTH - 3;
    localparam int S1_B = DEPTH - 8;
    localparam int S1_C = DEPTH - 14;
    localparam int S2_A = DEPTH - 2;
    localparam int S2_B = DEPTH - 7;
    localparam int S2_C = DEPTH - 15;

    word_t sha1_w;
    word_t sha2_w;

    always_comb begin
        sha1_w = rotl1(win_i[S1_A] ^ win_i[S1_B] ^ win_i[S1_C] ^ win_i[0]);
        sha2_w = lsig1(win_i[S2_A]) + win_i[S2_B] + lsig0(win_i[S2_C]) + win_i[0];
        next_o = (alg_i == ALG_SHA1) ? sha1_w : sha2_w;
    end
endmodule

// File: rtl/sched_window.sv
`timescale 1ns/1ps
module sched_window
    import msg_sched_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_i,
    input  logic                         sel_load_i,
    input  word_t                        load_word_i,
    input  word_t                        exp_word_i,
    input  logic                         take_i,
    output logic [DEPTH-1:0][WORD_W-1:0] win_o,
    output word_t                        word_o
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] win;
        word_t                        out;
    } win_t;

    win_t win_d, win_q;
    word_t incoming;

    always_comb begin
        win_d    = win_q;
        incoming = sel_load_i ? load_word_i : exp_word_i;
        if (take_i) begin
            win_d.out = win_q.win[0];
        end
        if (shift_i) begin
            win_d.win = {incoming, win_q.win[DEPTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win_o  = win_q.win;
    assign word_o = win_q.out;
endmodule

// File: rtl/sched_ctrl.sv
`timescale 1ns/1ps
module sched_ctrl
    import msg_sched_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int ROUNDS_SHA1 = 80,
    parameter int ROUNDS_SHA2 = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic load_valid_i,
    input  logic adv_i,
    output logic shift_o,
    output logic sel_load_o,
    output logic take_o,
    output alg_e alg_o,
    output logic valid_o,
    output logic last_o
);
    localparam int MAX_ROUNDS = (ROUNDS_SHA1 > ROUNDS_SHA2) ? ROUNDS_SHA1 : ROUNDS_SHA2;
    localparam int CNT_W      = $clog2(MAX_ROUNDS + 1);
    localparam int LD_W       = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] END_SHA1 = CNT_W'(ROUNDS_SHA1 - 1);
    localparam logic [CNT_W-1:0] END_SHA2 = CNT_W'(ROUNDS_SHA2 - 1);
    localparam logic [LD_W-1:0]  LD_END   = LD_W'(DEPTH - 1);

    typedef struct packed {
        sched_state_e     st;
        alg_e             alg;
        logic [LD_W-1:0]  ldcnt;
        logic [CNT_W-1:0] round;
        logic             valid;
        logic             last;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [CNT_W-1:0] end_round;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        ctl_d.last  = 1'b0;
        shift_o     = 1'b0;
        sel_load_o  = 1'b0;
        take_o      = 1'b0;
        end_round   = (ctl_q.alg == ALG_SHA1) ? END_SHA1 : END_SHA2;
        case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (load_valid_i) begin
                    ctl_d.alg   = alg_e'(mode_i);
                    ctl_d.ldcnt = LD_W'(1);
                    ctl_d.st    = ST_LOAD;
                    shift_o     = 1'b1;
                    sel_load_o  = 1'b1;
                end
            end
            ST_LOAD: begin
                if (load_valid_i) begin
                    shift_o    = 1'b1;
                    sel_load_o = 1'b1;
                    if (ctl_q.ldcnt == LD_END) begin
                        ctl_d.st    = ST_RUN;
                        ctl_d.ldcnt = '0;
                        ctl_d.round = '0;
                    end else begin
                        ctl_d.ldcnt = ctl_q.ldcnt + LD_W'(1);
                    end
                end
            end
            ST_RUN: begin
                if (adv_i) begin
                    take_o      = 1'b1;
                    shift_o     = 1'b1;
                    ctl_d.valid = 1'b1;
                    if (ctl_q.round == end_round) begin
                        ctl_d.last = 1'b1;
                        ctl_d.st   = ST_DONE;
                    end else begin
                        ctl_d.round = ctl_q.round + CNT_W'(1);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, alg: ALG_SHA1, ldcnt: '0, round: '0,
                       valid: 1'b0, last: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign alg_o   = ctl_q.alg;
    assign valid_o = ctl_q.valid;
    assign last_o  = ctl_q.last;
endmodule

// File: rtl/msg_sched_dual.sv
`timescale 1ns/1ps
module msg_sched_dual
    import msg_sched_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int ROUNDS_SHA1 = 80,
    parameter int ROUNDS_SHA2 = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_i,
    input  logic        load_valid_i,
    input  logic [31:0] load_word_i,
    input  logic        adv_i,
    output logic [31:0] word_o,
    output logic        word_valid_o,
    output logic        last_o
);
    logic                         shift;
    logic                         sel_load;
    logic                         take;
    alg_e                         alg;
    word_t                        exp_word;
    logic [DEPTH-1:0][WORD_W-1:0] win;

    sched_ctrl #(
        .DEPTH      (DEPTH),
        .ROUNDS_SHA1(ROUNDS_SHA1),
        .ROUNDS_SHA2(ROUNDS_SHA2)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .load_valid_i(load_valid_i),
        .adv_i       (adv_i),
        .shift_o     (shift),
        .sel_load_o  (sel_load),
        .take_o      (take),
        .alg_o       (alg),
        .valid_o     (word_valid_o),
        .last_o      (last_o)
    );

    sched_window #(
        .DEPTH(DEPTH)
    ) i_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (shift),
        .sel_load_i (sel_load),
        .load_word_i(load_word_i),
        .exp_word_i (exp_word),
        .take_i     (take),
        .win_o      (win),
        .word_o     (word_o)
    );

    sched_expand #(
        .DEPTH(DEPTH)
    ) i_expand (
        .win_i (win),
        .alg_i (alg),
        .next_o(exp_word)
    );
endmodule

// File: rtl/msg_sched_chk.sv
`timescale 1ns/1ps
module msg_sched_chk #(
    parameter int ROUNDS_SHA1 = 80,
    parameter int ROUNDS_SHA2 = 64
) (
    input logic clk,
    input logic rst_n,
    input logic adv_i,
    input logic load_valid_i,
    input logic word_valid_o,
    input logic last_o
);
    localparam int CW = $clog2(ROUNDS_SHA1 + ROUNDS_SHA2 + 2);

    logic [CW-1:0] vcnt_q;
    logic          seen_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt_q      <= '0;
            seen_last_q <= 1'b0;
        end else begin
            if (last_o) begin
                vcnt_q <= '0;
            end else if (word_valid_o) begin
                vcnt_q <= vcnt_q + CW'(1);
            end
            if (last_o) begin
                seen_last_q <= 1'b1;
            end else if (load_valid_i) begin
                seen_last_q <= 1'b0;
            end
        end
    end

    a_r7_valid_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(adv_i));

    a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> word_valid_o);

    // R5 and R6: last flag only on the final word of either length
    a_r6_last_position: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (vcnt_q == CW'(ROUNDS_SHA1 - 1) || vcnt_q == CW'(ROUNDS_SHA2 - 1)));

    a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (vcnt_q < CW'(ROUNDS_SHA1)));

    a_r8_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        seen_last_q |-> !word_valid_o);
endmodule

bind msg_sched_dual msg_sched_chk #(
    .ROUNDS_SHA1(ROUNDS_SHA1),
    .ROUNDS_SHA2(ROUNDS_SHA2)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (adv_i),
    .load_valid_i(load_valid_i),
    .word_valid_o(word_valid_o),
    .last_o      (last_o)
);

// File: tb/test_msg_sched_dual.sv
`timescale 1ns/1ps
module test_msg_sched_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic        load_valid_i = 1'b0;
    logic [31:0] load_word_i = '0;
    logic        adv_i = 1'b0;
    logic [31:0] word_o;
    logic        word_valid_o;
    logic        last_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] msg [16];
    logic [31:0] ref_w [80];

    always #2.5 clk = ~clk;

    msg_sched_dual i_msg_sched_dual (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .load_valid_i(load_valid_i),
        .load_word_i (load_word_i),
        .adv_i       (adv_i),
        .word_o      (word_o),
        .word_valid_o(word_valid_o),
        .last_o      (last_o)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic build_ref(input logic sha256);
        for (int t = 0; t < 80; t++) begin
            if (t < 16) begin
                ref_w[t] = msg[t];
            end else if (!sha256) begin
                logic [31:0] x;
                x = ref_w[t-3] ^ ref_w[t-8] ^ ref_w[t-14] ^ ref_w[t-16];
                ref_w[t] = {x[30:0], x[31]};
            end else begin
                logic [31:0] a;
                logic [31:0] b;
                a = rr(ref_w[t-15], 7) ^ rr(ref_w[t-15], 18) ^ (ref_w[t-15] >> 3);
                b = rr(ref_w[t-2], 17) ^ rr(ref_w[t-2], 19) ^ (ref_w[t-2] >> 10);
                ref_w[t] = b + ref_w[t-7] + a + ref_w[t-16];
            end
        end
    endtask

    task automatic fill_msg(input logic [31:0] seed);
        for (int i = 0; i < 16; i++) begin
            msg[i] = (seed * (i + 3)) ^ {i[7:0], 24'h5a3c01} ^ rr(seed, i + 1);
        end
    endtask

    // load sixteen words; mode applied on word 0, optional other mode afterward; optional adv pulses
    task automatic load_block(input logic m, input logic flip, input logic adv_during);
        for (int i = 0; i < 16; i++) begin
            load_valid_i = 1'b1;
            load_word_i  = msg[i];
            mode_i       = (i == 0) ? m : (flip ? ~m : m);
            adv_i        = adv_during && (i % 3 == 1);
            @(negedge clk);
            if (adv_during) chk("R10 adv during load", {31'b0, word_valid_o}, 32'd0);
        end
        load_valid_i = 1'b0;
        adv_i        = 1'b0;
        mode_i       = 1'b0;
    endtask

    task automatic adv_step(input int t, input int n, input logic sha256);
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        chk("R7 valid after adv", {31'b0, word_valid_o}, 32'd1);
        if (t < 16)       chk("R2 loaded word", word_o, ref_w[t]);
        else if (!sha256) chk("R3 sha1 expansion", word_o, ref_w[t]);
        else              chk("R4 sha256 expansion", word_o, ref_w[t]);
        chk(sha256 ? "R6 last flag" : "R5 last flag", {31'b0, last_o},
            {31'b0, (t == n - 1)});
    endtask

    task automatic run_block(input logic sha256, input int gap, input logic junk_load);
        int n;
        n = sha256 ? 64 : 80;
        for (int t = 0; t < n; t++) begin
            adv_step(t, n, sha256);
            for (int g = 0; g < gap; g++) begin
                if (junk_load && t == 20) begin
                    load_valid_i = 1'b1;
                    load_word_i  = 32'hdead0000 + g;
                    mode_i       = ~sha256;
                end
                @(negedge clk);
                load_valid_i = 1'b0;
                chk(junk_load ? "R11 load ignored in run" : "R7 no valid in gap",
                    {31'b0, word_valid_o}, 32'd0);
            end
        end
    endtask

    task automatic t_reset;
        chk("R1 reset valid", {31'b0, word_valid_o}, 32'd0);
        chk("R1 reset last", {31'b0, last_o}, 32'd0);
        chk("R1 reset word", word_o, 32'd0);
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        @(negedge clk);
        chk("R1 adv before load", {31'b0, word_valid_o}, 32'd0);
    endtask

    task automatic t_sha1_basic;
        fill_msg(32'h61626380);
        build_ref(1'b0);
        load_block(1'b0, 1'b0, 1'b0);
        run_block(1'b0, 0, 1'b0);
    endtask

    task automatic t_after_last;
        for (int i = 0; i < 4; i++) begin
            adv_i = 1'b1;
            @(negedge clk);
            chk("R8 adv after last", {31'b0, word_valid_o}, 32'd0);
        end
        adv_i = 1'b0;
    endtask

    task automatic t_sha256_gaps;
        fill_msg(32'h9e3779b9);
        build_ref(1'b1);
        load_block(1'b1, 1'b0, 1'b0);
        run_block(1'b1, 2, 1'b0);
    endtask

    task automatic t_mode_flip;
        fill_msg(32'h0badf00d);
        build_ref(1'b1);
        load_block(1'b1, 1'b1, 1'b0);
        for (int t = 0; t < 64; t++) begin
            adv_step(t, 64, 1'b1);
            if (t >= 16) chk("R9 mode held from first word", word_o, ref_w[t]);
        end
        fill_msg(32'h13572468);
        build_ref(1'b0);
        load_block(1'b0, 1'b1, 1'b0);
        run_block(1'b0, 0, 1'b0);
    endtask

    task automatic t_adv_in_load;
        fill_msg(32'hc001d00d);
        build_ref(1'b0);
        load_block(1'b0, 1'b0, 1'b1);
        adv_step(0, 80, 1'b0);
        chk("R10 first word after load", word_o, msg[0]);
        for (int t = 1; t < 80; t++) adv_step(t, 80, 1'b0);
    endtask

    task automatic t_load_in_run;
        fill_msg(32'h7fffffff);
        build_ref(1'b1);
        load_block(1'b1, 1'b0, 1'b0);
        run_block(1'b1, 1, 1'b1);
        t_after_last();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sha1_basic();
        t_after_last();
        t_sha256_gaps();
        t_after_last();
        t_mode_flip();
        t_adv_in_load();
        t_load_in_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule